// File: doc/BRIEF.md
# DMA FIFO Threshold and Burst Legality Gate

This block sits beside one DMA stream and decides, when software turns the stream on, whether the FIFO threshold and the burst settings can work together. The FIFO holds 16 bytes. The threshold picks a quarter, a half, three quarters or all of it. The block checks two things. First, the selected level must split into whole memory bursts. Second, the memory and peripheral burst footprints must fit in the FIFO. When the FIFO is in use, a peripheral burst that fills the whole FIFO also rules out the three-quarter level.

The configuration is sampled on the rising edge of the enable request. An accepted setting turns the stream on and keeps it on while the request stays high. A rejected setting also turns the stream on for one cycle. In the cycle after that, the block switches the stream off and raises a sticky FIFO error flag. Software clears the flag by writing a one to the clear input. The block ignores any new enable until the flag is cleared.

Top module: `fifo_burst_gate`

## Requirements
- R1: After reset, `stream_en_o` and `fifo_err_o` are both 0.
- R2: The threshold code `thr_sel` selects 4, 8, 12 or 16 bytes (codes 0, 1, 2, 3). The memory burst code `mem_burst` selects single, 4, 8 or 16 beats (codes 0, 1, 2, 3). The size codes select 1, 2 or 4 bytes (codes 0, 1, 2). In FIFO mode, a non-single memory burst is legal only when the threshold bytes are an exact multiple of beats × memory size.
- R3: In FIFO mode, the setting faults when either port has a non-single burst whose beats × size exceeds 16 bytes, or when either size code equals the reserved value 3.
- R4: In FIFO mode, a non-single peripheral burst whose beats × size equals 16 bytes makes threshold code 2 (three quarters) a fault.
- R5: A single memory burst (code 0) never faults against the threshold.
- R6: A rising edge of `stream_en_req` while the flag is clear drives `stream_en_o` to 1 at the next clock edge.
- R7: On a faulting setting, `stream_en_o` is 1 for exactly one cycle. At the following edge it returns to 0 and `fifo_err_o` rises.
- R8: `fifo_err_o` stays 1 until a clock edge that sees `fifo_err_clr` = 1. If a fault is set in the same edge as a clear, the flag stays 1.
- R9: While `fifo_err_o` is 1, a rising edge of `stream_en_req` is ignored and `stream_en_o` stays 0. Once the flag is cleared, a legal enable is accepted again.
- R10: `stream_en_o` goes to 0 at the first edge that sees `stream_en_req` low. Configuration changes while the stream is enabled have no effect.
- R11: With `fifo_mode` = 0 (direct mode), no combination of threshold, burst or size faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_sel | input | 2 | FIFO threshold code |
| mem_burst | input | 2 | Memory burst length code |
| mem_size | input | 2 | Memory data size code |
| per_burst | input | 2 | Peripheral burst length code |
| per_size | input | 2 | Peripheral data size code |
| fifo_mode | input | 1 | 1 = FIFO used (direct mode off) |
| stream_en_req | input | 1 | Software enable request, level |
| fifo_err_clr | input | 1 | Write-one-to-clear of the error flag |
| stream_en_o | output | 1 | Actual stream enabled state |
| fifo_err_o | output | 1 | Sticky FIFO configuration error flag |

## Verification
The fault-setting step of a rejected enable and a software clear of the flag can land on the same clock edge. The bench provokes this by holding `fifo_err_clr` high in the cycle that follows an illegal enable, and it expects the flag to stay 1 because setting has priority. A second coincidence is an enable edge that arrives while a clear is pending. The bench expects that enable to be ignored, because the decision uses the flag as it stood before the edge. A behavioural model that scores the legality rules with integer division judges every cycle of an exhaustive sweep over all configuration codes.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    // Threshold fraction codes: the value is the quarter count minus one
    typedef enum logic [1:0] {
        THR_Q1   = 2'd0,
        THR_HALF = 2'd1,
        THR_Q3   = 2'd2,
        THR_FULL = 2'd3
    } thr_code_e;

    // Burst codes: 0 is a single beat, otherwise 2^(code+1) beats
    localparam logic [1:0] BURST_SINGLE = 2'd0;
    localparam logic [1:0] SIZE_RSVD    = 2'd3;

    // Largest shift exponent: burst 3 (16 beats) plus size 2 (4 bytes)
    localparam int MAX_EXP = 6;
    localparam int SPAN_W  = MAX_EXP + 1;

    typedef struct packed {
        logic en_prev;   // request as seen at the last edge
        logic stream_en; // stream running
        logic pend;      // enable accepted last edge, verdict waiting
        logic pend_bad;  // verdict captured at the enable edge
        logic err;       // sticky fault flag
    } gate_state_t;

endpackage

// File: rtl/xfer_span.sv
module xfer_span
    import fbg_pkg::*;
#(
    parameter int FIFO_BYTES = 16
) (
    input  logic [1:0]        burst_code,
    input  logic [1:0]        size_code,
    output logic              is_single,
    output logic              rsvd_size,
    output logic [SPAN_W-1:0] span_bytes,
    output logic              oversize
);
    logic [2:0] exp_w;

    always_comb begin
        exp_w      = 3'(burst_code) + 3'd1 + 3'(size_code);
        span_bytes = SPAN_W'(1) << exp_w;
        is_single  = (burst_code == BURST_SINGLE);
        rsvd_size  = (size_code == SIZE_RSVD);
        oversize   = (32'(span_bytes) > FIFO_BYTES);
    end

endmodule

// File: rtl/fifo_cfg_judge.sv
module fifo_cfg_judge
    import fbg_pkg::*;
#(
    parameter int FIFO_BYTES = 16
) (
    input  logic [1:0] thr_sel,
    input  logic [1:0] mem_burst,
    input  logic [1:0] mem_size,
    input  logic [1:0] per_burst,
    input  logic [1:0] per_size,
    input  logic       fifo_mode,
    output logic       cfg_bad
);
    localparam int QUARTER = FIFO_BYTES / 4;
    localparam int N_PORT  = 2; // 0 = memory side, 1 = peripheral side

    logic [1:0]        burst_a [N_PORT];
    logic [1:0]        size_a  [N_PORT];
    logic              single_a[N_PORT];
    logic              rsvd_a  [N_PORT];
    logic [SPAN_W-1:0] span_a  [N_PORT];
    logic              over_a  [N_PORT];

    assign burst_a[0] = mem_burst;
    assign size_a[0]  = mem_size;
    assign burst_a[1] = per_burst;
    assign size_a[1]  = per_size;

    for (genvar g = 0; g < N_PORT; g++) begin : g_port
        xfer_span #(.FIFO_BYTES(FIFO_BYTES)) u_span (
            .burst_code (burst_a[g]),
            .size_code  (size_a[g]),
            .is_single  (single_a[g]),
            .rsvd_size  (rsvd_a[g]),
            .span_bytes (span_a[g]),
            .oversize   (over_a[g])
        );
    end

    logic [SPAN_W-1:0] thr_bytes;
    logic              misfit;
    logic              mem_fault;
    logic              per_fault;
    logic              per_full;

    always_comb begin
        thr_bytes = SPAN_W'((32'(thr_sel) + 1) * QUARTER);
        // spans are powers of two, so a mask gives the remainder
        misfit    = (thr_bytes & (span_a[0] - SPAN_W'(1))) != '0;
        mem_fault = rsvd_a[0] | (!single_a[0] & (over_a[0] | misfit));
        per_full  = !single_a[1] & (32'(span_a[1]) == FIFO_BYTES);
        per_fault = rsvd_a[1] | (!single_a[1] & over_a[1])
                  | (per_full & (thr_sel == THR_Q3));
        cfg_bad   = fifo_mode & (mem_fault | per_fault);
    end

endmodule

// File: rtl/fifo_burst_gate.sv
module fifo_burst_gate
    import fbg_pkg::*;
#(
    parameter int FIFO_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] thr_sel,
    input  logic [1:0] mem_burst,
    input  logic [1:0] mem_size,
    input  logic [1:0] per_burst,
    input  logic [1:0] per_size,
    input  logic       fifo_mode,
    input  logic       stream_en_req,
    input  logic       fifo_err_clr,
    output logic       stream_en_o,
    output logic       fifo_err_o
);
    logic        cfg_bad;
    logic        en_rise;
    gate_state_t st_d, st_q;

    fifo_cfg_judge #(.FIFO_BYTES(FIFO_BYTES)) u_judge (
        .thr_sel   (thr_sel),
        .mem_burst (mem_burst),
        .mem_size  (mem_size),
        .per_burst (per_burst),
        .per_size  (per_size),
        .fifo_mode (fifo_mode),
        .cfg_bad   (cfg_bad)
    );

    always_comb begin
        st_d         = st_q;
        en_rise      = stream_en_req & !st_q.en_prev;
        st_d.en_prev = stream_en_req;
        st_d.pend    = 1'b0;

        // setting the flag outranks a software clear
        if (st_q.pend && st_q.pend_bad) begin
            st_d.stream_en = 1'b0;
            st_d.err       = 1'b1;
        end else if (fifo_err_clr) begin
            st_d.err = 1'b0;
        end

        if (!stream_en_req) begin
            st_d.stream_en = 1'b0;
        end else if (en_rise && !st_q.err) begin
            st_d.stream_en = 1'b1;
            st_d.pend      = 1'b1;
            st_d.pend_bad  = cfg_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stream_en_o = st_q.stream_en;
    assign fifo_err_o  = st_q.err;

    // R7
    fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_err_o) |-> !stream_en_o);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_err_o && !fifo_err_clr) |=> fifo_err_o);

    // R9
    blocked_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_err_o && !stream_en_o) |=> !stream_en_o);

    // R10
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_en_req |=> !stream_en_o);

    // R6
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stream_en_o) |-> ($past(stream_en_req) && !$past(fifo_err_o)));

    // R11
    direct_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> !cfg_bad);

endmodule

// File: tb/fifo_burst_gate_tb.sv
`timescale 1ns/1ps
module fifo_burst_gate_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] thr_sel = '0, mem_burst = '0, mem_size = '0;
    logic [1:0] per_burst = '0, per_size = '0;
    logic       fifo_mode = 1'b1, stream_en_req = 1'b0, fifo_err_clr = 1'b0;
    logic       stream_en_o, fifo_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fifo_burst_gate dut_i (
        .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel), .mem_burst(mem_burst),
        .mem_size(mem_size), .per_burst(per_burst), .per_size(per_size),
        .fifo_mode(fifo_mode), .stream_en_req(stream_en_req),
        .fifo_err_clr(fifo_err_clr), .stream_en_o(stream_en_o),
        .fifo_err_o(fifo_err_o)
    );

    // legality rules scored with integer arithmetic
    function automatic bit legal_ref(int t, int mb, int ms, int pb, int ps, bit fm);
        int thr_b, m_b, p_b;
        if (!fm) return 1'b1;                 // R11
        if (ms == 3 || ps == 3) return 1'b0;  // R3 reserved sizes
        thr_b = 4 * (t + 1);
        if (mb != 0) begin
            m_b = (2 ** (mb + 1)) * (2 ** ms);
            if (m_b > 16) return 1'b0;        // R3
            if (thr_b % m_b != 0) return 1'b0; // R2
        end
        if (pb != 0) begin
            p_b = (2 ** (pb + 1)) * (2 ** ps);
            if (p_b > 16) return 1'b0;        // R3
            if (p_b == 16 && t == 2) return 1'b0; // R4
        end
        return 1'b1;
    endfunction

    // cycle model
    bit m_prev, m_en, m_pend, m_bad, m_err;
    always @(posedge clk) begin
        bit n_en, n_err, n_pend, n_bad;
        if (!rst_n) begin
            m_prev = 0; m_en = 0; m_pend = 0; m_bad = 0; m_err = 0;
        end else begin
            n_en = m_en; n_err = m_err; n_pend = 0; n_bad = m_bad;
            if (m_pend && m_bad) begin n_en = 0; n_err = 1; end
            else if (fifo_err_clr) n_err = 0;
            if (!stream_en_req) n_en = 0;
            else if (!m_prev && !m_err) begin
                n_en = 1; n_pend = 1;
                n_bad = !legal_ref(int'(thr_sel), int'(mem_burst), int'(mem_size),
                                   int'(per_burst), int'(per_size), fifo_mode);
            end
            m_prev = stream_en_req;
            m_en = n_en; m_err = n_err; m_pend = n_pend; m_bad = n_bad;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (stream_en_o !== m_en) begin
                errors++;
                $display("FAIL R6 model stream_en actual=%0b expected=%0b t=%0t", stream_en_o, m_en, $time);
            end
            checks++;
            if (fifo_err_o !== m_err) begin
                errors++;
                $display("FAIL R8 model fifo_err actual=%0b expected=%0b t=%0t", fifo_err_o, m_err, $time);
            end
        end
    end

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic set_cfg(int t, int mb, int ms, int pb, int ps, bit fm);
        thr_sel = 2'(t); mem_burst = 2'(mb); mem_size = 2'(ms);
        per_burst = 2'(pb); per_size = 2'(ps); fifo_mode = fm;
    endtask

    // enable with current config; returns after the verdict edge
    task automatic try_enable(string req, bit exp_ok);
        stream_en_req = 1'b1;
        @(negedge clk);
        chk({req, " R6 enable glimpse"}, stream_en_o, 1'b1);
        @(negedge clk);
        chk({req, " R7 verdict en"}, stream_en_o, exp_ok);
        chk({req, " R7 verdict err"}, fifo_err_o, !exp_ok);
    endtask

    task automatic release_clear();
        stream_en_req = 1'b0; fifo_err_clr = 1'b1;
        @(negedge clk);
        chk("R10 drop", stream_en_o, 1'b0);
        chk("R8 cleared", fifo_err_o, 1'b0);
        fifo_err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset en", stream_en_o, 1'b0);
        chk("R1 reset err", fifo_err_o, 1'b0);

        // directed examples
        set_cfg(0, 1, 0, 0, 0, 1); try_enable("R2 byte x4 at quarter", 1'b1); release_clear();
        set_cfg(2, 3, 0, 0, 0, 1); try_enable("R2 byte x16 at 3/4", 1'b0); release_clear();
        set_cfg(3, 3, 0, 0, 0, 1); try_enable("R2 byte x16 at full", 1'b1); release_clear();
        set_cfg(1, 1, 1, 0, 0, 1); try_enable("R2 half x4 at half", 1'b1); release_clear();
        set_cfg(1, 1, 2, 0, 0, 1); try_enable("R2 word x4 at half", 1'b0); release_clear();
        set_cfg(3, 2, 2, 0, 0, 1); try_enable("R3 mem span 32", 1'b0); release_clear();
        set_cfg(3, 0, 3, 0, 0, 1); try_enable("R3 reserved size", 1'b0); release_clear();
        set_cfg(2, 0, 2, 1, 2, 1); try_enable("R4 per full at 3/4", 1'b0); release_clear();
        set_cfg(1, 0, 2, 1, 2, 1); try_enable("R4 per full at half", 1'b1); release_clear();
        set_cfg(0, 0, 2, 0, 0, 1); try_enable("R5 single at quarter", 1'b1); release_clear();
        set_cfg(2, 3, 2, 3, 2, 0); try_enable("R11 direct mode", 1'b1); release_clear();

        // R10: config change while running has no effect
        set_cfg(3, 1, 0, 0, 0, 1); try_enable("R10 base", 1'b1);
        set_cfg(2, 3, 2, 3, 2, 1);
        repeat (3) @(negedge clk);
        chk("R10 stays on", stream_en_o, 1'b1);
        chk("R10 no fault", fifo_err_o, 1'b0);
        release_clear();

        // R8: fault set and clear on the same edge, set wins
        set_cfg(0, 3, 0, 0, 0, 1);
        stream_en_req = 1'b1;
        @(negedge clk);
        fifo_err_clr = 1'b1;
        @(negedge clk);
        chk("R8 set beats clear", fifo_err_o, 1'b1);
        fifo_err_clr = 1'b0;
        stream_en_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 sticky", fifo_err_o, 1'b1);

        // R9: enable ignored while flag set, even with clear on same edge
        set_cfg(3, 1, 0, 0, 0, 1);
        stream_en_req = 1'b1;
        @(negedge clk);
        chk("R9 blocked", stream_en_o, 1'b0);
        stream_en_req = 1'b0; @(negedge clk);
        stream_en_req = 1'b1; fifo_err_clr = 1'b1;
        @(negedge clk);
        fifo_err_clr = 1'b0;
        chk("R9 blocked on clear edge", stream_en_o, 1'b0);
        chk("R9 flag cleared", fifo_err_o, 1'b0);
        stream_en_req = 1'b0; @(negedge clk);
        try_enable("R9 accepted after clear", 1'b1);
        release_clear();

        // exhaustive sweep over all codes
        for (int fm = 0; fm < 2; fm++)
            for (int t = 0; t < 4; t++)
                for (int mb = 0; mb < 4; mb++)
                    for (int ms = 0; ms < 4; ms++)
                        for (int pb = 0; pb < 4; pb++)
                            for (int ps = 0; ps < 4; ps++) begin
                                set_cfg(t, mb, ms, pb, ps, fm[0]);
                                try_enable("R2 sweep", legal_ref(t, mb, ms, pb, ps, fm[0]));
                                release_clear();
                            end

        finish_up();
    end

endmodule